// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This unit sits on the bus side of a 16-bit processor that has a 20-bit physical address space. It keeps a code segment value and a prefetch offset, and it turns the pair into a physical fetch address. While enough room is free, it requests instruction bytes from a shared memory port and places them in a six-byte FIFO. The execution side takes one byte at a time through a valid/ready pair, so fetching overlaps with execution, and the next opcode is normally already queued when the decoder needs it.

Memory returns at most two bytes per request. An odd offset first gets a single-byte fetch, and every later fetch is an aligned word. When a data access from the execution side and a pending prefetch both want the idle bus, the data access goes first. A control transfer raises the flush input together with a new segment and offset. The flush clears the queue, drops any fetch response still in flight, and restarts fetching at the new target. After reset the stream starts at segment FFFFh, offset 0000h.

Top module: `pfq_top`

## Requirements
- R1: The queue holds at most 6 bytes. Bytes are delivered on `ex_byte_o` in fetch order, one byte per cycle in which `ex_valid_o` and `ex_ready_i` are both high.
- R2: The fetch address is (segment × 16 + offset) mod 2^20. Segment 2000h with offset 1234h gives 21234h.
- R3: In the cycle after `flush_i` is high, `ex_valid_o` is low. The following fetches read from the new segment and offset.
- R4: A word fetch (`mem_word_o`=1) is issued only at an even address and only when at least 2 slots are free. Its byte on `mem_rdata_i[7:0]` enters the queue before the byte on `mem_rdata_i[15:8]`.
- R5: At an odd offset a single-byte fetch (`mem_word_o`=0) is issued. Its byte is taken from `mem_rdata_i[15:8]`, and the next fetch is a word at the following even address.
- R6: When a data request (`dreq_i`) and a pending fetch both want the idle bus, the data request is issued first (`mem_data_o`=1, `dgnt_o` pulses for one cycle) and prefetching resumes afterwards. A bus request stays steady until `mem_ack_i`.
- R7: A fetch response that arrives after a flush is discarded and never reaches the queue.
- R8: The prefetch offset advances by the number of bytes accepted and wraps from FFFFh to 0000h in the same segment.
- R9: Prefetching continues while the execution side is not taking bytes, until the queue is full. With a full queue no fetch is requested.
- R10: During reset `ex_valid_o`, `mem_req_o` and `dgnt_o` are low. The first fetch after reset is a word at FFFF0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Control transfer: empty the queue and retarget |
| flush_seg_i | input | 16 | New code segment |
| flush_off_i | input | 16 | New offset |
| ex_byte_o | output | 8 | Oldest queued instruction byte |
| ex_valid_o | output | 1 | Queue not empty |
| ex_ready_i | input | 1 | Execution side takes the byte |
| dreq_i | input | 1 | Data access request from the execution side |
| dreq_addr_i | input | 20 | Data access physical address |
| dreq_word_i | input | 1 | Data access is a word |
| dgnt_o | output | 1 | One-cycle pulse: data request issued on the bus |
| mem_req_o | output | 1 | Bus request, held until acknowledged |
| mem_addr_o | output | 20 | Bus physical address |
| mem_word_o | output | 1 | 1 = two bytes, 0 = one byte |
| mem_data_o | output | 1 | 1 = data access, 0 = instruction fetch |
| mem_ack_i | input | 1 | Memory accepts the request |
| mem_rvalid_i | input | 1 | Response data valid |
| mem_rdata_i | input | 16 | Response data, even byte in [7:0] |

## Verification
The checker watches several rules on every cycle. The fill level never passes six. A byte waiting for the execution side stays steady until it is taken. The queue reads empty right after a flush. Word fetches use even addresses and only start with two free slots, and byte fetches use odd addresses. Bus requests hold steady until they are acknowledged, and a data grant always comes with a data request on the bus. Other behaviours need the bench's scenarios. These are the byte order and its content, the dropping of a stale response, the ordering of the first requests after a retarget (odd start, wrap at the top of the segment, data before fetch), the exact capacity seen at the ports, and the reset target.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int SEG_W = 16;
  localparam int OFF_W = 16;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_ASK  = 2'd1,
    BUS_WAIT = 2'd2
  } bus_state_t;
endpackage

// File: rtl/pfq_addr_gen.sv
module pfq_addr_gen #(
  parameter int AW = 20,
  parameter int SW = 16,
  parameter int OW = 16
) (
  input  logic [SW-1:0] seg_i,
  input  logic [OW-1:0] off_i,
  output logic [AW-1:0] phys_o
);
  localparam int SHIFT = AW - SW;
  localparam int PAD   = AW - OW;

  logic [AW-1:0] base;
  logic [AW-1:0] disp;

  assign base   = {seg_i, {SHIFT{1'b0}}};
  assign disp   = {{PAD{1'b0}}, off_i};
  // carry past the top bit is dropped: the sum wraps at 2^AW
  assign phys_o = base + disp;
endmodule

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo #(
  parameter int DEPTH = 6,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          wr_en_i,
  input  logic          wr_two_i,
  input  logic [7:0]    wr_lo_i,
  input  logic [7:0]    wr_hi_i,
  input  logic          rd_en_i,
  output logic [7:0]    rd_byte_o,
  output logic [CW-1:0] count_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    slot [DEPTH];
  logic [PW-1:0] wp, rp, wp_nx;
  logic [CW-1:0] n_in, n_out;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wp_nx     = step(wp);
  assign n_in      = wr_en_i ? (wr_two_i ? CW'(2) : CW'(1)) : '0;
  assign n_out     = rd_en_i ? CW'(1) : '0;
  assign rd_byte_o = slot[rp];

  // storage has no reset so it can map onto plain memory
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      slot[wp] <= wr_lo_i;
      if (wr_two_i) slot[wp_nx] <= wr_hi_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      wp      <= '0;
      rp      <= '0;
      count_o <= '0;
    end else begin
      if (wr_en_i) wp <= wr_two_i ? step(wp_nx) : wp_nx;
      if (rd_en_i) rp <= step(rp);
      count_o <= count_o + n_in - n_out;
    end
  end
endmodule

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl
  import pfq_pkg::*;
#(
  parameter int               AW        = 20,
  parameter int               CW        = 3,
  parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
  parameter logic [OFF_W-1:0] RESET_OFF = 16'h0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic [SEG_W-1:0] flush_seg_i,
  input  logic [OFF_W-1:0] flush_off_i,
  input  logic             dreq_i,
  input  logic [AW-1:0]    dreq_addr_i,
  input  logic             dreq_word_i,
  input  logic [CW-1:0]    free_i,
  input  logic [AW-1:0]    fetch_phys_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [OFF_W-1:0] off_o,
  input  logic             mem_ack_i,
  input  logic             mem_rvalid_i,
  input  logic [15:0]      mem_rdata_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_word_o,
  output logic             mem_data_o,
  output logic             dgnt_o,
  output logic             wr_en_o,
  output logic             wr_two_o,
  output logic [7:0]       wr_lo_o,
  output logic [7:0]       wr_hi_o
);
  bus_state_t st;
  logic       drop_q;
  logic       room;
  logic       take_rsp;
  logic       keep;

  // an odd offset needs one slot (byte fetch), an even one needs two
  assign room     = off_o[0] ? (free_i >= CW'(1)) : (free_i >= CW'(2));
  assign take_rsp = (st == BUS_WAIT) && mem_rvalid_i;
  assign keep     = take_rsp && !mem_data_o && !drop_q && !flush_i;

  assign wr_en_o  = keep;
  assign wr_two_o = mem_word_o;
  assign wr_lo_o  = mem_word_o ? mem_rdata_i[7:0] : mem_rdata_i[15:8];
  assign wr_hi_o  = mem_rdata_i[15:8];

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= BUS_IDLE;
      mem_req_o  <= 1'b0;
      mem_addr_o <= '0;
      mem_word_o <= 1'b0;
      mem_data_o <= 1'b0;
      dgnt_o     <= 1'b0;
    end else begin
      dgnt_o <= 1'b0;
      case (st)
        BUS_IDLE: begin
          if (!flush_i) begin
            if (dreq_i) begin
              mem_req_o  <= 1'b1;
              mem_addr_o <= dreq_addr_i;
              mem_word_o <= dreq_word_i;
              mem_data_o <= 1'b1;
              dgnt_o     <= 1'b1;
              st         <= BUS_ASK;
            end else if (room) begin
              mem_req_o  <= 1'b1;
              mem_addr_o <= fetch_phys_i;
              mem_word_o <= !off_o[0];
              mem_data_o <= 1'b0;
              st         <= BUS_ASK;
            end
          end
        end
        BUS_ASK: begin
          if (mem_ack_i) begin
            mem_req_o <= 1'b0;
            st        <= BUS_WAIT;
          end
        end
        BUS_WAIT: begin
          if (mem_rvalid_i) st <= BUS_IDLE;
        end
        default: st <= BUS_IDLE;
      endcase
    end
  end

  // a fetch in flight when a flush arrives belongs to the old stream
  always_ff @(posedge clk) begin
    if (rst) begin
      drop_q <= 1'b0;
    end else if (take_rsp) begin
      drop_q <= 1'b0;
    end else if (flush_i && (st != BUS_IDLE) && !mem_data_o) begin
      drop_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_o <= RESET_SEG;
      off_o <= RESET_OFF;
    end else if (flush_i) begin
      seg_o <= flush_seg_i;
      off_o <= flush_off_i;
    end else if (keep) begin
      off_o <= off_o + (mem_word_o ? OFF_W'(2) : OFF_W'(1));
    end
  end
endmodule

// File: rtl/pfq_top.sv
module pfq_top
  import pfq_pkg::*;
#(
  parameter int               AW        = 20,
  parameter int               DEPTH     = 6,
  parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
  parameter logic [OFF_W-1:0] RESET_OFF = 16'h0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic [SEG_W-1:0] flush_seg_i,
  input  logic [OFF_W-1:0] flush_off_i,
  output logic [7:0]       ex_byte_o,
  output logic             ex_valid_o,
  input  logic             ex_ready_i,
  input  logic             dreq_i,
  input  logic [AW-1:0]    dreq_addr_i,
  input  logic             dreq_word_i,
  output logic             dgnt_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_word_o,
  output logic             mem_data_o,
  input  logic             mem_ack_i,
  input  logic             mem_rvalid_i,
  input  logic [15:0]      mem_rdata_i
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]    fifo_count;
  logic [CW-1:0]    free;
  logic [SEG_W-1:0] cur_seg;
  logic [OFF_W-1:0] cur_off;
  logic [AW-1:0]    fetch_phys;
  logic             wr_en, wr_two, rd_en;
  logic [7:0]       wr_lo, wr_hi;

  assign free       = CW'(DEPTH) - fifo_count;
  assign ex_valid_o = (fifo_count != '0);
  assign rd_en      = ex_valid_o && ex_ready_i && !flush_i;

  pfq_addr_gen #(.AW(AW), .SW(SEG_W), .OW(OFF_W)) u_agen (
    .seg_i  (cur_seg),
    .off_i  (cur_off),
    .phys_o (fetch_phys)
  );

  pfq_fetch_ctrl #(
    .AW(AW), .CW(CW), .RESET_SEG(RESET_SEG), .RESET_OFF(RESET_OFF)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .flush_i      (flush_i),
    .flush_seg_i  (flush_seg_i),
    .flush_off_i  (flush_off_i),
    .dreq_i       (dreq_i),
    .dreq_addr_i  (dreq_addr_i),
    .dreq_word_i  (dreq_word_i),
    .free_i       (free),
    .fetch_phys_i (fetch_phys),
    .seg_o        (cur_seg),
    .off_o        (cur_off),
    .mem_ack_i    (mem_ack_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_word_o   (mem_word_o),
    .mem_data_o   (mem_data_o),
    .dgnt_o       (dgnt_o),
    .wr_en_o      (wr_en),
    .wr_two_o     (wr_two),
    .wr_lo_o      (wr_lo),
    .wr_hi_o      (wr_hi)
  );

  pfq_byte_fifo #(.DEPTH(DEPTH), .CW(CW)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (flush_i),
    .wr_en_i   (wr_en),
    .wr_two_i  (wr_two),
    .wr_lo_i   (wr_lo),
    .wr_hi_i   (wr_hi),
    .rd_en_i   (rd_en),
    .rd_byte_o (ex_byte_o),
    .count_o   (fifo_count)
  );
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int DEPTH = 6,
  parameter int AW    = 20,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          flush_i,
  input logic          ex_valid_o,
  input logic          ex_ready_i,
  input logic [7:0]    ex_byte_o,
  input logic          mem_req_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_word_o,
  input logic          mem_data_o,
  input logic          dgnt_o,
  input logic [CW-1:0] count
);
  assert_depth_R1: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    ex_valid_o && !ex_ready_i && !flush_i |=> ex_valid_o && $stable(ex_byte_o));

  assert_flush_empty_R3: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !ex_valid_o);

  assert_word_even_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_data_o && mem_word_o |-> !mem_addr_o[0]);

  assert_word_room_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_o) && !mem_data_o && mem_word_o |-> count <= CW'(DEPTH - 2));

  assert_byte_odd_R5: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_data_o && !mem_word_o |-> mem_addr_o[0]);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o));

  assert_grant_R6: assert property (@(posedge clk) disable iff (rst)
    dgnt_o |-> mem_req_o && mem_data_o);
endmodule

bind pfq_top pfq_checker #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .flush_i    (flush_i),
  .ex_valid_o (ex_valid_o),
  .ex_ready_i (ex_ready_i),
  .ex_byte_o  (ex_byte_o),
  .mem_req_o  (mem_req_o),
  .mem_ack_i  (mem_ack_i),
  .mem_addr_o (mem_addr_o),
  .mem_word_o (mem_word_o),
  .mem_data_o (mem_data_o),
  .dgnt_o     (dgnt_o),
  .count      (fifo_count)
);

// File: tb/sim_pfq_top.sv
`timescale 1ns/1ps
module sim_pfq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush_i = 1'b0;
  logic [15:0] flush_seg_i = '0;
  logic [15:0] flush_off_i = '0;
  logic [7:0]  ex_byte_o;
  logic        ex_valid_o;
  logic        ex_ready_i = 1'b1;
  logic        dreq_i = 1'b0;
  logic [19:0] dreq_addr_i = '0;
  logic        dreq_word_i = 1'b0;
  logic        dgnt_o;
  logic        mem_req_o;
  logic [19:0] mem_addr_o;
  logic        mem_word_o;
  logic        mem_data_o;
  logic        mem_ack_i = 1'b0;
  logic        mem_rvalid_i = 1'b0;
  logic [15:0] mem_rdata_i = '0;

  always #2 clk = ~clk;

  pfq_top u0 (.*);

  int errors = 0;
  int checks = 0;
  int pop_cnt = 0;
  bit done = 0;

  logic [7:0] exp_q[$];

  // memory model state
  int          lat = 2;
  bit          stall = 0;
  int          pend = 0;
  logic [19:0] paddr;
  logic        pword;
  logic        prev_req = 1'b0;
  int          lg_n = 0;
  logic [19:0] lg_addr [8];
  logic        lg_word [8];
  logic        lg_data [8];

  function automatic logic [7:0] mdata(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A;
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_stream(input logic [15:0] s, input logic [15:0] o);
    exp_q.delete();
    for (int k = 0; k < 200; k++) exp_q.push_back(mdata(phys(s, o + 16'(k))));
  endtask

  task automatic do_flush(input logic [15:0] s, input logic [15:0] o, input bit with_dreq);
    @(negedge clk);
    flush_i = 1'b1;
    flush_seg_i = s;
    flush_off_i = o;
    if (with_dreq) dreq_i = 1'b1;
    load_stream(s, o);
    @(negedge clk);
    flush_i = 1'b0;
    lg_n = 0;
    #1;
    check(ex_valid_o == 1'b0, "R3 empty after flush", 32'(ex_valid_o), 32'd0);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // memory model: acknowledge, then answer after lat cycles
  initial begin
    forever begin
      @(negedge clk);
      mem_ack_i = 1'b0;
      mem_rvalid_i = 1'b0;
      if (mem_req_o && !prev_req && lg_n < 8) begin
        lg_addr[lg_n] = mem_addr_o;
        lg_word[lg_n] = mem_word_o;
        lg_data[lg_n] = mem_data_o;
        lg_n++;
      end
      prev_req = mem_req_o;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rvalid_i = 1'b1;
          if (pword) mem_rdata_i = {mdata(paddr + 20'd1), mdata(paddr)};
          else if (paddr[0]) mem_rdata_i = {mdata(paddr), 8'h00};
          else mem_rdata_i = {8'h00, mdata(paddr)};
        end
      end else if (mem_req_o && !stall) begin
        mem_ack_i = 1'b1;
        paddr = mem_addr_o;
        pword = mem_word_o;
        pend = lat;
      end
    end
  end

  // monitor: compare each delivered byte with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && ex_valid_o && ex_ready_i && !flush_i) begin
        pop_cnt++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 order (queue empty)", 32'(ex_byte_o), 32'd0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(ex_byte_o == e, "R1 order", 32'(ex_byte_o), 32'(e));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    load_stream(16'hFFFF, 16'h0000);
    wait_cycles(4);
    #1;
    check(ex_valid_o == 1'b0, "R10 reset valid", 32'(ex_valid_o), 32'd0);
    check(mem_req_o == 1'b0, "R10 reset req", 32'(mem_req_o), 32'd0);
    check(dgnt_o == 1'b0, "R10 reset grant", 32'(dgnt_o), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    lg_n = 0;
    wait_cycles(30);
    check(lg_addr[0] == 20'hFFFF0 && lg_word[0], "R10 first fetch", 32'(lg_addr[0]), 32'hFFFF0);

    // R2: segment 2000h, offset 1234h
    do_flush(16'h2000, 16'h1234, 1'b0);
    wait_cycles(30);
    check(lg_addr[0] == 20'h21234, "R2 address", 32'(lg_addr[0]), 32'h21234);

    // R9 / R1: fill while stalled consumer, then count capacity
    @(negedge clk);
    ex_ready_i = 1'b0;
    do_flush(16'h4000, 16'h0100, 1'b0);
    wait_cycles(60);
    #1;
    check(ex_valid_o == 1'b1, "R9 filled while idle", 32'(ex_valid_o), 32'd1);
    check(mem_req_o == 1'b0, "R9 no fetch when full", 32'(mem_req_o), 32'd0);
    @(negedge clk);
    stall = 1;
    pop_cnt = 0;
    ex_ready_i = 1'b1;
    wait_cycles(12);
    #2;
    check(pop_cnt == 6, "R1 capacity six", 32'(pop_cnt), 32'd6);
    @(negedge clk);
    stall = 0;
    wait_cycles(20);

    // R5: odd start
    do_flush(16'h1000, 16'h0003, 1'b0);
    wait_cycles(30);
    check(lg_addr[0] == 20'h10003 && !lg_word[0], "R5 byte fetch", 32'(lg_addr[0]), 32'h10003);
    check(lg_addr[1] == 20'h10004 && lg_word[1], "R5 then word", 32'(lg_addr[1]), 32'h10004);

    // R8: wrap inside the segment
    do_flush(16'h3000, 16'hFFFD, 1'b0);
    wait_cycles(40);
    check(lg_addr[0] == 20'h3FFFD && !lg_word[0], "R8 odd top", 32'(lg_addr[0]), 32'h3FFFD);
    check(lg_addr[1] == 20'h3FFFE && lg_word[1], "R8 last word", 32'(lg_addr[1]), 32'h3FFFE);
    check(lg_addr[2] == 20'h30000 && lg_word[2], "R8 wrapped", 32'(lg_addr[2]), 32'h30000);

    // R6: data request beats the pending fetch
    dreq_addr_i = 20'hABCDE;
    dreq_word_i = 1'b1;
    do_flush(16'h5000, 16'h0000, 1'b1);
    begin
      bit seen = 0;
      for (int i = 0; i < 50 && !seen; i++) begin
        if (dgnt_o) seen = 1;
        else begin @(negedge clk); #1; end
      end
      check(seen, "R6 grant pulse", 32'(seen), 32'd1);
    end
    @(negedge clk);
    dreq_i = 1'b0;
    wait_cycles(20);
    check(lg_data[0] && lg_addr[0] == 20'hABCDE, "R6 data first", 32'(lg_addr[0]), 32'hABCDE);
    check(!lg_data[1] && lg_addr[1] == 20'h50000, "R6 fetch resumes", 32'(lg_addr[1]), 32'h50000);

    // R7: stale response after a flush
    @(negedge clk);
    lat = 6;
    begin
      bit busy = 0;
      for (int i = 0; i < 100 && !busy; i++) begin
        @(negedge clk); #1;
        if (pend > 0) busy = 1;
      end
    end
    do_flush(16'h6000, 16'h0000, 1'b0);
    begin
      bit got = 0;
      for (int i = 0; i < 60 && !got; i++) begin
        @(negedge clk); #1;
        if (ex_valid_o) got = 1;
      end
      check(got && ex_byte_o == mdata(20'h60000), "R7 stale dropped",
            32'(ex_byte_o), 32'(mdata(20'h60000)));
    end
    lat = 2;
    wait_cycles(40);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule